// File: doc/BRIEF.md
# Multi-Cycle Instruction Step Sequencer

This block is the control state machine of a small multi-cycle processor. Each instruction is walked through a sequence of short clock cycles, one basic datapath action per cycle, and the length of that sequence depends on the instruction's class. A branch retires after three cycles, a register-register operation or a store after four, and a load after five. Short instructions therefore finish early instead of all of them waiting out a fixed worst-case period.

The sequencer sees only the 6-bit opcode field of the instruction being fetched, plus a start request and a synchronous reset. It drives one control strobe per datapath action. It also produces a one-cycle retirement pulse and two free-running counters, busy cycles and retired instructions. The ratio of the two counters gives the average cycles per instruction for whatever instruction mix runs. The datapath, the memories and the ALU sit outside this block.

Top module: `step_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the sequencer returns to the fetch step and both counters go to zero. With `start` low after reset, every strobe is low.
- R2: In the fetch step, a low `start` holds the sequencer there. No strobe is raised and neither counter changes.
- R3: The fetch step happens in a cycle where the sequencer is in fetch and `start` is high. In that cycle `ir_load` and `pc_update` are high and no other strobe is. The opcode present in that cycle picks the whole sequence, and later changes on `opcode` or `start` during the instruction have no effect.
- R4: Opcode 000000 (register-register ALU) runs 4 steps: fetch, then decode, then `alu_op`, then `rf_write` together with `done`.
- R5: Opcode 100011 (load) runs 5 steps: fetch, then decode, then `alu_op` (address), then `mem_rd`, then `rf_write` together with `done`.
- R6: Opcode 101011 (store) runs 4 steps: fetch, then decode, then `alu_op` (address), then `mem_wr` together with `done`. `rf_write` is never raised.
- R7: Opcode 000100 (branch-if-equal) runs 3 steps: fetch, then decode, then `alu_op` with `pc_update` and `done`. `rf_write` is never raised.
- R8: Any other opcode runs 3 steps: fetch, then decode, then a step with only `done` high.
- R9: The second step of every instruction is decode: `rf_read` is high and every other strobe is low.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. Each is high for at most one cycle per instruction.
- R11: `done` is high for exactly one cycle, the final step. If `start` is high in the cycle after it, that cycle is the next fetch step, with no gap.
- R12: `cycle_count` adds one for every step cycle, including fetch steps but not idle cycles in fetch. `retired_count` adds one at the edge that ends each `done` cycle. Both counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a fetch step |
| opcode | input | OP_W | Opcode field of the word being fetched |
| ir_load | output | 1 | Latch the instruction register |
| rf_read | output | 1 | Read the register file operands |
| alu_op | output | 1 | Perform the ALU operation or address sum |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| rf_write | output | 1 | Register file write-back |
| pc_update | output | 1 | Load a new program counter value |
| done | output | 1 | Instruction retires this cycle |
| cycle_count | output | CNT_W | Busy cycles since reset |
| retired_count | output | CNT_W | Retired instructions since reset |

## Verification
The bench drives each opcode class plus unlisted opcodes. It scrambles `opcode` and `start` after every fetch step, so a design that re-decodes the live input instead of the latched opcode would take a different path. It runs instructions back to back and with idle gaps. Counting idle cycles, or inserting a bubble after `done`, would put the cycle counter off from the model. A narrow counter in the bench forces wraparound, and a reset in the middle of a load must leave no strobe and both counters at zero.

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int OP_W = 6,
  parameter int CNT_W = 32,
  parameter logic [OP_W-1:0] OP_ALU   = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  opcode,
  output logic             ir_load,
  output logic             rf_read,
  output logic             alu_op,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             rf_write,
  output logic             pc_update,
  output logic             done,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retired_count
);

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEMRD, S_MEMWR, S_WB, S_BRANCH, S_NOP
  } step_t;

  step_t           step_q, step_d;
  logic [OP_W-1:0] op_q;
  logic            busy;

  assign busy = (step_q != S_FETCH) || start;

  always_comb begin
    step_d = step_q;
    case (step_q)
      S_FETCH:  if (start) step_d = S_DECODE;
      S_DECODE: begin
        if (op_q == OP_ALU || op_q == OP_LOAD || op_q == OP_STORE) step_d = S_EXEC;
        else if (op_q == OP_BEQ) step_d = S_BRANCH;
        else step_d = S_NOP;
      end
      S_EXEC: begin
        if (op_q == OP_LOAD) step_d = S_MEMRD;
        else if (op_q == OP_STORE) step_d = S_MEMWR;
        else step_d = S_WB;
      end
      S_MEMRD:  step_d = S_WB;
      default:  step_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q        <= S_FETCH;
      op_q          <= '0;
      cycle_count   <= '0;
      retired_count <= '0;
    end else begin
      step_q <= step_d;
      if (ir_load) op_q <= opcode;
      if (busy) cycle_count <= cycle_count + 1'b1;
      if (done) retired_count <= retired_count + 1'b1;
    end
  end

  assign ir_load   = (step_q == S_FETCH) && start;
  assign rf_read   = (step_q == S_DECODE);
  assign alu_op    = (step_q == S_EXEC) || (step_q == S_BRANCH);
  assign mem_rd    = (step_q == S_MEMRD);
  assign mem_wr    = (step_q == S_MEMWR);
  assign rf_write  = (step_q == S_WB);
  assign pc_update = ir_load || (step_q == S_BRANCH);
  assign done      = (step_q == S_WB) || (step_q == S_MEMWR) ||
                     (step_q == S_BRANCH) || (step_q == S_NOP);

endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ir_load,
  input logic             rf_read,
  input logic             alu_op,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             rf_write,
  input logic             done,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] retired_count
);

  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r10_mem_rd_single: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r10_mem_wr_single: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (rf_read && !ir_load && !alu_op && !rf_write && !done));

  a_r5_load_writeback: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (rf_write && done));

  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!rf_write && done));

  a_r12_retire_step: assert property (@(posedge clk) disable iff (rst)
    done |=> retired_count == CNT_W'($past(retired_count) + 1'b1));

  a_r12_retire_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(retired_count));

  a_r12_cycle_step: assert property (@(posedge clk) disable iff (rst)
    (ir_load || rf_read || alu_op || mem_rd || mem_wr || rf_write || done)
      |=> cycle_count == CNT_W'($past(cycle_count) + 1'b1));

endmodule

bind step_sequencer step_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ir_load(ir_load), .rf_read(rf_read),
  .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_write(rf_write),
  .done(done), .cycle_count(cycle_count), .retired_count(retired_count)
);

// File: tb/step_sequencer_test.sv
module step_sequencer_test;
  localparam int CW = 8;

  logic clk = 0, rst = 1, start = 0;
  logic [5:0] opcode = '0;
  logic ir_load, rf_read, alu_op, mem_rd, mem_wr, rf_write, pc_update, done;
  logic [CW-1:0] cycle_count, retired_count;
  int checks = 0, failures = 0;
  int exp_cyc = 0, exp_ret = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  step_sequencer #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .ir_load(ir_load), .rf_read(rf_read), .alu_op(alu_op), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .rf_write(rf_write), .pc_update(pc_update), .done(done),
    .cycle_count(cycle_count), .retired_count(retired_count)
  );

  function automatic int n_steps(logic [5:0] op);
    case (op)
      6'b000000: return 4;
      6'b100011: return 5;
      6'b101011: return 4;
      default:   return 3;
    endcase
  endfunction

  // vector order: ir_load rf_read alu_op mem_rd mem_wr rf_write pc_update done
  function automatic logic [7:0] exp_vec(logic [5:0] op, int k);
    if (k == 0) return 8'b1000_0010;
    if (k == 1) return 8'b0100_0000;
    case (op)
      6'b000000: return (k == 2) ? 8'b0010_0000 : 8'b0000_0101;
      6'b100011: return (k == 2) ? 8'b0010_0000 : (k == 3) ? 8'b0001_0000 : 8'b0000_0101;
      6'b101011: return (k == 2) ? 8'b0010_0000 : 8'b0000_1001;
      6'b000100: return 8'b0010_0011;
      default:   return 8'b0000_0001;
    endcase
  endfunction

  function automatic string req_of(logic [5:0] op, int k);
    if (k == 0) return "R3";
    if (k == 1) return "R9";
    case (op)
      6'b000000: return "R4/R11";
      6'b100011: return "R5/R11";
      6'b101011: return "R6/R11";
      6'b000100: return "R7/R11";
      default:   return "R8/R11";
    endcase
  endfunction

  function automatic logic [7:0] act_vec();
    return {ir_load, rf_read, alu_op, mem_rd, mem_wr, rf_write, pc_update, done};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_counts(string req);
    check(cycle_count == CW'(exp_cyc), {req, " cycle_count"}, 32'(cycle_count), 32'(CW'(exp_cyc)));
    check(retired_count == CW'(exp_ret), {req, " retired_count"}, 32'(retired_count), 32'(CW'(exp_ret)));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      start = 0;
      opcode = 6'($urandom);
      #1;
      check(act_vec() == 8'h00, "R2 idle strobes", 32'(act_vec()), 0);
      @(negedge clk);
    end
    #1;
    check_counts("R2 idle");
  endtask

  task automatic run_one(logic [5:0] op);
    int n = n_steps(op);
    int rd = 0, wr = 0;
    opcode = op;
    start = 1;
    for (int k = 0; k < n; k++) begin
      #1;
      check(act_vec() == exp_vec(op, k), req_of(op, k), 32'(act_vec()), 32'(exp_vec(op, k)));
      rd += mem_rd;
      wr += mem_wr;
      if (mem_rd && mem_wr) check(0, "R10 both memory strobes", 1, 0);
      exp_cyc++;
      if (k == n - 1) exp_ret++;
      @(negedge clk);
      opcode = 6'($urandom);
      start = 1'($urandom);
    end
    check(rd <= 1 && wr <= 1, "R10 memory strobe count", 32'(rd * 16 + wr), 32'h11);
    #1;
    check_counts("R12");
    start = 0;
  endtask

  initial begin
    logic [5:0] ops [5];
    ops[0] = 6'b000000; ops[1] = 6'b100011; ops[2] = 6'b101011;
    ops[3] = 6'b000100; ops[4] = 6'b111111;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(act_vec() == 8'h00, "R1 reset strobes", 32'(act_vec()), 0);
    check_counts("R1");
    @(negedge clk);
    idle(3);
    for (int i = 0; i < 5; i++) run_one(ops[i]);
    for (int i = 0; i < 5; i++) begin
      run_one(ops[i]);
      idle(1);
    end
    run_one(6'b010101);
    run_one(6'b100010);
    for (int i = 0; i < 300; i++) begin
      logic [5:0] op = ($urandom % 4 == 0) ? 6'($urandom) : ops[$urandom % 4];
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
      run_one(op);
    end
    opcode = 6'b100011;
    start = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 1;
    start = 0;
    @(negedge clk);
    rst = 0;
    exp_cyc = 0;
    exp_ret = 0;
    #1;
    check(act_vec() == 8'h00, "R1 mid-run reset strobes", 32'(act_vec()), 0);
    check_counts("R1 mid-run");
    @(negedge clk);
    run_one(6'b100011);
    run_one(6'b000100);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R11 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule